// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of an integrating analog-to-digital converter. It runs from a free-running oscillator clock and a single comparator bit. It steps the analog switches through four phases: auto-zero, signal integrate, reference de-integrate and zero integrate. While de-integrate runs, it counts in decimal how long the integrator takes to return to zero. That count is the reading.

A prescaler turns every PRESCALE oscillator clocks into one count. Signal integrate has a fixed length. De-integrate stops at the first count in which the comparator shows that the integrator has crossed zero, or at a hard limit, which marks the result as overrange. The zero-integrate phase follows. It is short after an in-range result and long after an overrange result. Auto-zero then takes whatever remains of the cycle, so every conversion spans the same number of counts. The result is copied into an output latch, together with its sign and an overrange flag, under a one-clock strobe. The latch holds its value until the next strobe.

Top module: `dsadc_sequencer`

## Requirements
- R1: The phases run in the fixed order auto-zero, signal integrate, de-integrate, zero integrate, then auto-zero again. At any time exactly one of `az_o`, `sig_int_o`, `ref_dn_o`, `ref_up_o`, `zi_o` is high.
- R2: Signal integrate lasts exactly INT_COUNTS counts, which is INT_COUNTS*PRESCALE clocks.
- R3: `cmp_pos_i` is sampled at the last count of signal integrate. A high level means positive: de-integrate drives `ref_dn_o` and the latched `rdg_neg_o` is 0. A low level means negative: de-integrate drives `ref_up_o` and `rdg_neg_o` is 1. The chosen direction does not change during de-integrate.
- R4: De-integrate ends at the first count boundary at which `cmp_pos_i` differs from the level sampled in R3. The reading is the number of counts completed before that boundary, and de-integrate lasts reading+1 counts.
- R5: If DEINT_MAX counts pass without a crossing, de-integrate ends. The result is latched with `rdg_ovr_o`=1 and the reading DEINT_MAX-1.
- R6: Zero integrate lasts ZI_SHORT_CNT counts after an in-range result and ZI_LONG_CNT counts after an overrange result.
- R7: Phases change only at count boundaries. The start of one signal-integrate phase and the start of the next are always CYCLE_COUNTS*PRESCALE clocks apart, whatever the reading.
- R8: `rdg_stb_o` is high for one clock, which is the first clock of zero integrate. `rdg_o`, `rdg_neg_o` and `rdg_ovr_o` change only in the clock where the strobe is high.
- R9: `rdg_o` holds NDIG binary-coded decimal digits. Digit k sits in bits [4k+3:4k], so the units digit is in bits [3:0].
- R10: A synchronous reset puts the block in auto-zero with the strobe, the reading and both flags at 0. Signal integrate then begins (CYCLE_COUNTS-INT_COUNTS-DEINT_MAX)*PRESCALE clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_pos_i | input | 1 | Comparator: 1 when the integrator is above zero |
| az_o | output | 1 | Auto-zero switch phase |
| sig_int_o | output | 1 | Signal integrate switch phase |
| ref_dn_o | output | 1 | De-integrate with the reference driving the integrator down |
| ref_up_o | output | 1 | De-integrate with the reference driving the integrator up |
| zi_o | output | 1 | Zero integrate switch phase |
| rdg_o | output | 4*NDIG | Latched reading in BCD |
| rdg_neg_o | output | 1 | Latched sign, 1 for a negative input |
| rdg_ovr_o | output | 1 | Latched overrange flag |
| rdg_stb_o | output | 1 | One-clock pulse when the latch is loaded |

## Verification
The bench drives the comparator from a behavioural integrator, so the block has to close its own loop. Inputs one below the limit and exactly at the limit separate an off-by-one in the crossing-versus-limit priority: that design would flag the wrong case as overrange or report a reading one count off. Readings of 9, 10 and 100 test digit carries, which a binary counter or a broken carry chain would corrupt. A small input following an overrange tests whether the long zero-integrate phase is actually used and whether auto-zero shrinks to keep the cycle length fixed; a design that ignored either would show a wrong zero-integrate length or a drifting cycle. A reset in the middle of de-integrate must clear the latch and restart the full first auto-zero.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    // Conversion phases, in the order they occur within one cycle.
    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DEI = 2'd2,
        PH_ZI  = 2'd3
    } phase_e;

endpackage

// File: rtl/dsadc_tick_div.sv
module dsadc_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_d, div_q;

    always_comb begin
        div_d = (div_q == LAST) ? '0 : div_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end

    assign tick_o = (div_q == LAST);

    // R7: the divider steps through its whole range, so a tick recurs every DIV clocks.
    p_tick_spacing_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick_o)) |-> (div_q == '0));

endmodule

// File: rtl/dsadc_bcd_count.sv
module dsadc_bcd_count #(
    parameter int NDIG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [4*NDIG-1:0] val_o
);
    logic [NDIG-1:0] carry;
    assign carry[0] = inc_i;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [3:0] dig_d, dig_q;

        always_comb begin
            dig_d = dig_q;
            if (clr_i)         dig_d = 4'd0;
            else if (carry[g]) dig_d = (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
        end

        always_ff @(posedge clk) begin
            if (rst) dig_q <= 4'd0;
            else     dig_q <= dig_d;
        end

        if (g < NDIG - 1) begin : g_carry
            assign carry[g+1] = carry[g] && (dig_q == 4'd9);
        end

        assign val_o[4*g +: 4] = dig_q;

        // R9: every digit stays a legal decimal value.
        p_digit_legal_r9: assert property (@(posedge clk) disable iff (rst)
            dig_q <= 4'd9);
    end

endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
    import dsadc_pkg::*;
#(
    parameter int PRESCALE     = 4,
    parameter int INT_COUNTS   = 1000,
    parameter int DEINT_MAX    = 2000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int ZI_SHORT_CNT = 16,
    parameter int ZI_LONG_CNT  = 185,
    parameter int NDIG         = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_pos_i,
    output logic              az_o,
    output logic              sig_int_o,
    output logic              ref_dn_o,
    output logic              ref_up_o,
    output logic              zi_o,
    output logic [4*NDIG-1:0] rdg_o,
    output logic              rdg_neg_o,
    output logic              rdg_ovr_o,
    output logic              rdg_stb_o
);
    localparam int CNT_W = $clog2(CYCLE_COUNTS + 1);
    localparam int RD_W  = 4 * NDIG;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t INT_LAST     = cnt_t'(INT_COUNTS - 1);
    localparam cnt_t DEI_LAST     = cnt_t'(DEINT_MAX - 1);
    localparam cnt_t AZ_BUDGET    = cnt_t'(CYCLE_COUNTS - INT_COUNTS);
    localparam cnt_t AZ_AFTER_RST = cnt_t'(CYCLE_COUNTS - INT_COUNTS - DEINT_MAX);
    localparam cnt_t ZI_SHORT     = cnt_t'(ZI_SHORT_CNT);
    localparam cnt_t ZI_LONG      = cnt_t'(ZI_LONG_CNT);

    typedef struct packed {
        phase_e          phase;
        cnt_t            pcnt;     // counts completed in the current phase
        cnt_t            az_len;   // auto-zero length for this cycle
        cnt_t            zi_len;   // zero-integrate length for this cycle
        logic            neg;      // polarity sampled at end of integrate
        logic [RD_W-1:0] rdg;
        logic            rdg_neg;
        logic            rdg_ovr;
        logic            stb;
    } seq_s;

    localparam seq_s SEQ_RST = '{
        phase:   PH_AZ,
        pcnt:    '0,
        az_len:  AZ_AFTER_RST,
        zi_len:  ZI_SHORT,
        neg:     1'b0,
        rdg:     '0,
        rdg_neg: 1'b0,
        rdg_ovr: 1'b0,
        stb:     1'b0
    };

    seq_s            seq_d, seq_q;
    logic            tick;
    logic            bcd_clr, bcd_inc;
    logic            crossed;
    cnt_t            zi_pick;
    logic [RD_W-1:0] bcd_val;

    dsadc_tick_div #(.DIV(PRESCALE)) u_div (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    dsadc_bcd_count #(.NDIG(NDIG)) u_bcd (
        .clk   (clk),
        .rst   (rst),
        .clr_i (bcd_clr),
        .inc_i (bcd_inc),
        .val_o (bcd_val)
    );

    always_comb begin
        seq_d   = seq_q;
        seq_d.stb = 1'b0;
        bcd_clr = 1'b0;
        bcd_inc = 1'b0;
        // Crossing: comparator now shows the opposite side to the sampled one.
        crossed = (cmp_pos_i == seq_q.neg);
        zi_pick = crossed ? ZI_SHORT : ZI_LONG;

        if (tick) begin
            unique case (seq_q.phase)
                PH_AZ: begin
                    if (seq_q.pcnt == seq_q.az_len - cnt_t'(1)) begin
                        seq_d.phase = PH_INT;
                        seq_d.pcnt  = '0;
                    end else begin
                        seq_d.pcnt  = seq_q.pcnt + cnt_t'(1);
                    end
                end
                PH_INT: begin
                    if (seq_q.pcnt == INT_LAST) begin
                        seq_d.phase = PH_DEI;
                        seq_d.pcnt  = '0;
                        seq_d.neg   = ~cmp_pos_i;
                        bcd_clr     = 1'b1;
                    end else begin
                        seq_d.pcnt  = seq_q.pcnt + cnt_t'(1);
                    end
                end
                PH_DEI: begin
                    if (crossed || seq_q.pcnt == DEI_LAST) begin
                        seq_d.phase   = PH_ZI;
                        seq_d.pcnt    = '0;
                        seq_d.rdg     = bcd_val;
                        seq_d.rdg_neg = seq_q.neg;
                        seq_d.rdg_ovr = ~crossed;
                        seq_d.stb     = 1'b1;
                        seq_d.zi_len  = zi_pick;
                        // Auto-zero absorbs what de-integrate and zero integrate left.
                        seq_d.az_len  = AZ_BUDGET - (seq_q.pcnt + cnt_t'(1)) - zi_pick;
                    end else begin
                        seq_d.pcnt    = seq_q.pcnt + cnt_t'(1);
                        bcd_inc       = 1'b1;
                    end
                end
                PH_ZI: begin
                    if (seq_q.pcnt == seq_q.zi_len - cnt_t'(1)) begin
                        seq_d.phase = PH_AZ;
                        seq_d.pcnt  = '0;
                    end else begin
                        seq_d.pcnt  = seq_q.pcnt + cnt_t'(1);
                    end
                end
                default: seq_d.phase = PH_AZ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= SEQ_RST;
        else     seq_q <= seq_d;
    end

    assign az_o      = (seq_q.phase == PH_AZ);
    assign sig_int_o = (seq_q.phase == PH_INT);
    assign ref_dn_o  = (seq_q.phase == PH_DEI) && !seq_q.neg;
    assign ref_up_o  = (seq_q.phase == PH_DEI) &&  seq_q.neg;
    assign zi_o      = (seq_q.phase == PH_ZI);
    assign rdg_o     = seq_q.rdg;
    assign rdg_neg_o = seq_q.rdg_neg;
    assign rdg_ovr_o = seq_q.rdg_ovr;
    assign rdg_stb_o = seq_q.stb;

    // R1: each phase hands over only to its successor.
    p_az_to_int_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(az_o)) |-> sig_int_o);
    p_int_to_dei_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(sig_int_o)) |-> (ref_dn_o || ref_up_o));
    p_dei_to_zi_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(ref_dn_o || ref_up_o)) |-> zi_o);
    p_zi_to_az_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(zi_o)) |-> az_o);

    // R3: reference direction is fixed for the whole de-integrate phase.
    p_dir_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ref_dn_o || ref_up_o) && (ref_dn_o || ref_up_o))
            |-> $stable(ref_up_o));

    // R5: de-integrate never runs past its limit.
    p_dei_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_DEI) |-> (seq_q.pcnt <= DEI_LAST));

    // R7: phases change only at a prescaler tick.
    p_phase_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && seq_q.phase != $past(seq_q.phase)) |-> $past(tick));

    // R8: strobe is a single clock, right after de-integrate, and the latch holds otherwise.
    p_stb_single_r8: assert property (@(posedge clk) disable iff (rst)
        rdg_stb_o |=> !rdg_stb_o);
    p_stb_after_dei_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rdg_stb_o) |-> (zi_o && $past(ref_dn_o || ref_up_o)));
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !rdg_stb_o) |-> ($stable(rdg_o) && $stable(rdg_neg_o) && $stable(rdg_ovr_o)));

endmodule

// File: tb/sim_dsadc_sequencer.sv
module sim_dsadc_sequencer;
    localparam int PS = 4;
    localparam int NI = 100;
    localparam int NDM = 200;
    localparam int NC = 400;
    localparam int ZS = 4;
    localparam int ZL = 46;
    localparam int ND = 3;
    localparam int NV = 11;

    typedef struct packed {
        logic signed [15:0] vin;
        logic [15:0]        rd;
        logic               neg;
        logic               nchk;
        logic               ovr;
    } vec_t;

    // vin, expected reading, expected sign, sign checked, expected overrange
    localparam vec_t VEC [NV] = '{
        '{16'sd57,   16'd57,  1'b0, 1'b1, 1'b0},
        '{-16'sd123, 16'd123, 1'b1, 1'b1, 1'b0},
        '{16'sd0,    16'd0,   1'b0, 1'b0, 1'b0},
        '{16'sd199,  16'd199, 1'b0, 1'b1, 1'b0},
        '{16'sd200,  16'd199, 1'b0, 1'b1, 1'b1},
        '{-16'sd250, 16'd199, 1'b1, 1'b1, 1'b1},
        '{16'sd1,    16'd1,   1'b0, 1'b1, 1'b0},
        '{-16'sd1,   16'd1,   1'b1, 1'b1, 1'b0},
        '{16'sd9,    16'd9,   1'b0, 1'b1, 1'b0},
        '{16'sd10,   16'd10,  1'b0, 1'b1, 1'b0},
        '{-16'sd100, 16'd100, 1'b1, 1'b1, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmp = 1'b1;
    logic            az, sint, rdn, rup, zi, neg, ovr, stb;
    logic [4*ND-1:0] rdg;

    int nchk = 0, nfail = 0;
    int vin = 0, integ = 0;
    int clk_cnt = 0, rel_cnt = 0, last_rise = 0, period = 0;
    int run_int = 0, run_dei = 0, run_zi = 0;
    int int_len = 0, dei_len = 0, zi_len = 0;
    int order_err = 0, glitch = 0;
    int prev_code = 0;
    logic prev_int = 0, prev_dei = 0, prev_zi = 0, used_neg = 0;
    logic [4*ND-1:0] prev_rdg = '0;
    logic prev_neg = 0, prev_ovr_o = 0;

    always #5 clk = ~clk;

    dsadc_sequencer #(
        .PRESCALE(PS), .INT_COUNTS(NI), .DEINT_MAX(NDM), .CYCLE_COUNTS(NC),
        .ZI_SHORT_CNT(ZS), .ZI_LONG_CNT(ZL), .NDIG(ND)
    ) u0 (
        .clk(clk), .rst(rst), .cmp_pos_i(cmp),
        .az_o(az), .sig_int_o(sint), .ref_dn_o(rdn), .ref_up_o(rup), .zi_o(zi),
        .rdg_o(rdg), .rdg_neg_o(neg), .rdg_ovr_o(ovr), .rdg_stb_o(stb)
    );

    // Behavioural integrator and comparator; at exactly zero the comparator holds.
    always @(negedge clk) begin
        if (rst || az || zi) integ = 0;
        else if (sint)       integ = integ + vin;
        else if (rdn)        integ = integ - NI;
        else if (rup)        integ = integ + NI;
        if (integ > 0)      cmp = 1'b1;
        else if (integ < 0) cmp = 1'b0;
    end

    // Phase length, period, order and latch-stability monitor.
    always @(negedge clk) begin
        int code;
        clk_cnt = clk_cnt + 1;
        code = az ? 0 : sint ? 1 : (rdn || rup) ? 2 : 3;
        if (!rst && code != prev_code && code != (prev_code + 1) % 4) order_err++;
        prev_code = code;
        if (sint && !prev_int) begin period = clk_cnt - last_rise; last_rise = clk_cnt; end
        if ((rdn || rup) && !prev_dei) used_neg = rup;
        if (sint) run_int++; else if (prev_int) begin int_len = run_int; run_int = 0; end
        if (rdn || rup) run_dei++; else if (prev_dei) begin dei_len = run_dei; run_dei = 0; end
        if (zi) run_zi++; else if (prev_zi) begin zi_len = run_zi; run_zi = 0; end
        if (rst) begin run_int = 0; run_dei = 0; run_zi = 0; end
        if (!rst && !stb && (rdg != prev_rdg || neg != prev_neg || ovr != prev_ovr_o)) glitch++;
        prev_int = sint; prev_dei = rdn || rup; prev_zi = zi;
        prev_rdg = rdg; prev_neg = neg; prev_ovr_o = ovr;
    end

    function automatic logic [4*ND-1:0] to_bcd(input int v);
        logic [4*ND-1:0] r;
        int t;
        t = v;
        for (int k = 0; k < ND; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_stb();
        do @(negedge clk); while (!stb);
        #1;
    endtask

    task automatic chk_reset_state();
        chk(az && !sint && !rdn && !rup && !zi, "R10", "phase is auto-zero only",
            int'({az, sint, rdn, rup, zi}), 16);
        chk(rdg == '0 && !neg && !ovr && !stb, "R10", "latch and strobe cleared",
            int'({rdg, neg, ovr, stb}), 0);
    endtask

    initial begin
        logic last_ovr;
        bit   first;
        last_ovr = 1'b0;
        first = 1'b1;
        vin = VEC[0].vin;
        repeat (4) @(negedge clk);
        #1;
        chk_reset_state();
        rst = 1'b0;
        rel_cnt = clk_cnt;

        for (int i = 0; i < NV; i++) begin
            vin = VEC[i].vin;
            wait_stb();
            chk(rdg == to_bcd(int'(VEC[i].rd)), "R4 R9", "BCD reading", int'(rdg),
                int'(to_bcd(int'(VEC[i].rd))));
            chk(ovr == VEC[i].ovr, "R5", "overrange flag", int'(ovr), int'(VEC[i].ovr));
            if (VEC[i].nchk) begin
                chk(neg == VEC[i].neg, "R3", "latched sign", int'(neg), int'(VEC[i].neg));
                chk(used_neg == VEC[i].neg, "R3", "reference direction", int'(used_neg),
                    int'(VEC[i].neg));
            end
            chk(dei_len == PS * (VEC[i].ovr ? NDM : int'(VEC[i].rd) + 1), "R4", "de-integrate clocks",
                dei_len, PS * (VEC[i].ovr ? NDM : int'(VEC[i].rd) + 1));
            chk(int_len == PS * NI, "R2", "integrate clocks", int_len, PS * NI);
            if (first) begin
                chk(last_rise - rel_cnt == PS * (NC - NI - NDM), "R10", "first auto-zero clocks",
                    last_rise - rel_cnt, PS * (NC - NI - NDM));
            end else begin
                chk(period == PS * NC, "R7", "cycle clocks", period, PS * NC);
                chk(zi_len == PS * (last_ovr ? ZL : ZS), "R6", "zero-integrate clocks",
                    zi_len, PS * (last_ovr ? ZL : ZS));
            end
            @(negedge clk);
            #1;
            chk(!stb, "R8", "strobe width", int'(stb), 0);
            last_ovr = VEC[i].ovr;
            first = 1'b0;
        end

        // Reset in the middle of de-integrate.
        vin = 150;
        do @(negedge clk); while (!(rdn || rup));
        repeat (10) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk_reset_state();
        rst = 1'b0;
        rel_cnt = clk_cnt;
        vin = 42;
        wait_stb();
        chk(rdg == to_bcd(42), "R10", "reading after reset", int'(rdg), int'(to_bcd(42)));
        chk(last_rise - rel_cnt == PS * (NC - NI - NDM), "R10", "auto-zero after reset",
            last_rise - rel_cnt, PS * (NC - NI - NDM));

        chk(order_err == 0, "R1", "phase order errors", order_err, 0);
        chk(glitch == 0, "R8", "latch changes without strobe", glitch, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R7 watchdog: actual %0d clocks expected completion", 150000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule